// File: doc/BRIEF.md
# Serial Configuration Bitstream Loader

This block takes a configuration bitstream that arrives one bit at a time on a serial data pin. It packs the bits into bytes for a downstream frame writer. Bits are packed most significant first. The block has two ways of getting its bit clock. In master mode it generates the configuration clock itself by dividing the system clock, and it drives that clock out. In slave mode an external controller supplies the bit clock. That clock and the data are brought into the system clock domain through synchronisers, and a bit is taken on each detected rising edge.

Nothing is captured until the initialisation-ready input has been seen high. At that point the block latches the expected byte count. It then assembles bytes until that many have been delivered, each one with a single-cycle valid strobe. After the final byte it raises a one-cycle load-done pulse, which tells the CRC check to start. The block then stays idle until the next reset. The chip-select and write-strobe inputs play no part in serial loading and are ignored.

Top module: `serial_cfg_loader`

## Requirements
- R1: While the asynchronous reset `rst_n` is low, and on its release, `byte_valid`, `load_done` and `cclk_out` are low, and the block waits for `init_ready`.
- R2: Before `init_ready` has been sampled high, no bit is captured, no byte is produced and `cclk_out` stays low, whatever `sclk_in` and `sdata_in` do.
- R3: In master mode, while loading, `cclk_out` is the system clock divided by 2*HALF_DIV. Its first rising edge comes HALF_DIV cycles after loading starts. In slave mode `cclk_out` stays low.
- R4: In master mode, the bit captured is the value of `sdata_in` at the system clock edge where `cclk_out` goes high.
- R5: In slave mode, `sclk_in` and `sdata_in` each pass through two flops. A bit is captured, equal to the synchronised data, in the cycle after the synchronised clock is seen to rise. High and low phases of `sclk_in` must last at least two system clocks.
- R6: Bytes are assembled most significant bit first: the first bit captured after a byte boundary appears in `byte_data[7]`.
- R7: On the clock edge that captures the eighth bit of a byte, `byte_valid` rises together with the completed `byte_data`, and it stays high for exactly one cycle.
- R8: `byte_total` is latched when loading starts. `load_done` pulses exactly once, in the same cycle as the final `byte_valid`. After that no further bytes are produced, and from the second cycle on `cclk_out` stays low until reset.
- R9: If the latched `byte_total` is zero, `load_done` pulses on the edge that samples `init_ready` high, and no byte is produced.
- R10: `cs_n` and `wr_n` have no effect. The byte stream, `load_done` and `cclk_out` are the same whatever those pins do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_mode | input | 1 | 1: generate the configuration clock; 0: use `sclk_in` |
| init_ready | input | 1 | Initialisation complete; loading may begin |
| byte_total | input | CNT_W | Number of bytes to load, latched at start |
| sclk_in | input | 1 | External configuration clock (slave mode) |
| sdata_in | input | 1 | Serial configuration data |
| cs_n | input | 1 | Chip select, ignored in serial loading |
| wr_n | input | 1 | Write strobe, ignored in serial loading |
| cclk_out | output | 1 | Generated configuration clock (master mode) |
| byte_data | output | DATA_W | Assembled byte |
| byte_valid | output | 1 | One-cycle strobe marking `byte_data` valid |
| load_done | output | 1 | One-cycle pulse requesting the CRC check |

## Verification
The hardest corner to reach is the boundary around the start of loading in slave mode. The stimulus toggles the external clock and data with `init_ready` low, which must produce nothing. It then raises `init_ready` during a quiet stretch of the clock, so that the first captured bit is exactly the first bit sent afterwards. Master-mode data is driven by a feeder that follows the generated clock. It changes the data only after each rising edge, which exercises the capture point. The slave stream is repeated at the minimum phase length, with `cs_n` and `wr_n` toggling every cycle, and the result is compared with a stream sent with those pins held still.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
    typedef enum logic [1:0] {
        LD_WAIT   = 2'd0,
        LD_SHIFT  = 2'd1,
        LD_FINISH = 2'd2
    } ld_state_e;
endpackage

// File: rtl/cfg_mclk_gen.sv
// Divides the system clock into the outgoing configuration clock while run is high.
module cfg_mclk_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic cclk,
    output logic rise_tick
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             level;
    } div_t;

    div_t d, q;
    logic wrap;

    always_comb begin
        wrap = (q.cnt == DIV_W'(HALF_DIV - 1));
        d    = q;
        if (!run) begin
            d.cnt   = '0;
            d.level = 1'b0;
        end else if (wrap) begin
            d.cnt   = '0;
            d.level = ~q.level;
        end else begin
            d.cnt = q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cclk      = q.level;
    assign rise_tick = run & wrap & ~q.level;
endmodule

// File: rtl/cfg_sclk_sync.sv
// Two-flop synchroniser for the external clock and data, with rising-edge detect.
module cfg_sclk_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic sdata_in,
    output logic rise_tick,
    output logic bit_out
);
    typedef struct packed {
        logic c1;
        logic c2;
        logic c_prev;
        logic s1;
        logic s2;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d.c1     = sclk_in;
        d.c2     = q.c1;
        d.c_prev = q.c2;
        d.s1     = sdata_in;
        d.s2     = q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rise_tick = q.c2 & ~q.c_prev;
    assign bit_out   = q.s2;
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int CNT_W    = 16,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              init_ready,
    input  logic [CNT_W-1:0]  byte_total,
    input  logic              sclk_in,
    input  logic              sdata_in,
    input  logic              cs_n,
    input  logic              wr_n,
    output logic              cclk_out,
    output logic [DATA_W-1:0] byte_data,
    output logic              byte_valid,
    output logic              load_done
);
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    typedef struct packed {
        ld_state_e         state;
        logic [CNT_W-1:0]  total;
        logic [CNT_W-1:0]  byte_cnt;
        logic [BIT_W-1:0]  bit_cnt;
        logic [DATA_W-1:0] shreg;
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              done;
    } ld_regs_t;

    ld_regs_t d, q;

    logic m_tick, m_run, s_tick, s_bit;
    logic tick, cap_bit;
    logic [DATA_W-1:0] next_sh;
    ld_state_e state_q;

    assign m_run = (q.state == LD_SHIFT) && master_mode;

    cfg_mclk_gen #(.HALF_DIV(HALF_DIV)) u_mclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (m_run),
        .cclk      (cclk_out),
        .rise_tick (m_tick)
    );

    cfg_sclk_sync u_ssync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_in   (sclk_in),
        .sdata_in  (sdata_in),
        .rise_tick (s_tick),
        .bit_out   (s_bit)
    );

    assign tick    = master_mode ? m_tick : s_tick;
    assign cap_bit = master_mode ? sdata_in : s_bit;
    assign next_sh = {q.shreg[DATA_W-2:0], cap_bit};

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        d.done  = 1'b0;
        unique case (q.state)
            LD_WAIT: begin
                if (init_ready) begin
                    d.total    = byte_total;
                    d.byte_cnt = '0;
                    d.bit_cnt  = '0;
                    d.shreg    = '0;
                    if (byte_total == '0) begin
                        d.state = LD_FINISH;
                        d.done  = 1'b1;
                    end else begin
                        d.state = LD_SHIFT;
                    end
                end
            end
            LD_SHIFT: begin
                if (tick) begin
                    d.shreg   = next_sh;
                    d.bit_cnt = q.bit_cnt + BIT_W'(1);
                    if (q.bit_cnt == BIT_W'(DATA_W - 1)) begin
                        d.bit_cnt  = '0;
                        d.data     = next_sh;
                        d.valid    = 1'b1;
                        d.byte_cnt = q.byte_cnt + CNT_W'(1);
                        if (q.byte_cnt + CNT_W'(1) == q.total) begin
                            d.state = LD_FINISH;
                            d.done  = 1'b1;
                        end
                    end
                end
            end
            default: begin
                d.state = LD_FINISH;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= LD_WAIT;
        end else begin
            q <= d;
        end
    end

    assign state_q    = q.state;
    assign byte_data  = q.data;
    assign byte_valid = q.valid;
    assign load_done  = q.done;
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk
    import cfg_loader_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      master_mode,
    input logic      cclk_out,
    input logic      byte_valid,
    input logic      load_done,
    input logic      cs_n,
    input logic      wr_n,
    input ld_state_e st
);
    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> !load_done);

    // R3
    slave_no_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> !cclk_out);

    // R2
    wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LD_WAIT) |-> (!byte_valid && !cclk_out && !load_done));

    // R8
    finish_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LD_FINISH && $past(st == LD_FINISH)) |-> (!byte_valid && !cclk_out));

    // R10
    ctl_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LD_SHIFT && !$stable({cs_n, wr_n})) |=> (st != LD_WAIT));
endmodule

bind serial_cfg_loader cfg_loader_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_mode (master_mode),
    .cclk_out    (cclk_out),
    .byte_valid  (byte_valid),
    .load_done   (load_done),
    .cs_n        (cs_n),
    .wr_n        (wr_n),
    .st          (state_q)
);

// File: tb/sim_serial_cfg_loader.sv
module sim_serial_cfg_loader;
    localparam int HALF = 2;
    localparam int CW   = 16;

    logic clk = 0, rst_n = 0, master_mode = 0, init_ready = 0;
    logic [CW-1:0] byte_total = '0;
    logic sclk_in = 0, sdata_in = 0, cs_n = 1, wr_n = 1;
    logic cclk_out, byte_valid, load_done;
    logic [7:0] byte_data;

    int n_chk = 0, n_fail = 0;

    serial_cfg_loader #(.HALF_DIV(HALF), .CNT_W(CW), .DATA_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .init_ready(init_ready),
        .byte_total(byte_total), .sclk_in(sclk_in), .sdata_in(sdata_in),
        .cs_n(cs_n), .wr_n(wr_n), .cclk_out(cclk_out), .byte_data(byte_data),
        .byte_valid(byte_valid), .load_done(load_done));

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference model state
    int  mst = 0, mdiv = 0, mtotal = 0, nbytes = 0, nbits = 0, acc = 0;
    bit  mcclk = 0, s1 = 0, s2 = 0, sprev = 0, d1 = 0, d2 = 0;
    bit  e_valid = 0, e_done = 0;
    int  e_data = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mst = 0; mdiv = 0; mtotal = 0; nbytes = 0; nbits = 0; acc = 0;
            mcclk = 0; s1 = 0; s2 = 0; sprev = 0; d1 = 0; d2 = 0;
            e_valid = 0; e_done = 0; e_data = 0;
        end else begin
            bit st, sb, mt, tk, bv;
            st = s2 && !sprev; sb = d2;
            sprev = s2; s2 = s1; s1 = sclk_in; d2 = d1; d1 = sdata_in;
            mt = (mst == 1) && master_mode && (mdiv == HALF - 1) && !mcclk;
            if (mst == 1 && master_mode) begin
                if (mdiv == HALF - 1) begin mdiv = 0; mcclk = !mcclk; end
                else mdiv++;
            end else begin
                mdiv = 0; mcclk = 0;
            end
            tk = master_mode ? mt : st;
            bv = master_mode ? sdata_in : sb;
            e_valid = 0; e_done = 0;
            if (mst == 0) begin
                if (init_ready) begin
                    mtotal = byte_total; nbytes = 0; nbits = 0; acc = 0;
                    if (mtotal == 0) begin mst = 2; e_done = 1; end
                    else mst = 1;
                end
            end else if (mst == 1 && tk) begin
                acc = ((acc << 1) | int'(bv)) & 255;
                nbits++;
                if (nbits == 8) begin
                    nbits = 0; e_valid = 1; e_data = acc; nbytes++;
                    if (nbytes == mtotal) begin mst = 2; e_done = 1; end
                end
            end
        end
    end

    logic [7:0] rx_q[$];
    logic [7:0] tx_q[$];
    int done_cnt = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            chk(byte_valid == e_valid, "R7 byte_valid", byte_valid, e_valid);
            if (e_valid) chk(byte_data == e_data[7:0], "R6 byte_data", byte_data, e_data);
            chk(load_done == e_done, "R8 load_done", load_done, e_done);
            chk(cclk_out == mcclk, "R3 cclk_out", cclk_out, mcclk);
            if (byte_valid) rx_q.push_back(byte_data);
            if (load_done) done_cnt++;
        end
    end

    function automatic bit tx_bit(input int i);
        logic [7:0] b;
        b = tx_q[i / 8];
        return b[7 - (i % 8)];
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; init_ready = 0; sclk_in = 0; sdata_in = 0; cs_n = 1; wr_n = 1;
        repeat (3) @(negedge clk);
        chk(!byte_valid && !load_done && !cclk_out, "R1 reset outputs", byte_valid, 0);
        rx_q.delete(); done_cnt = 0;
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit && done_cnt == 0; i++) @(negedge clk);
    endtask

    task automatic slave_bits(input int nb, input int lo, input int hi, input bit wiggle, input bit garbage);
        for (int i = 0; i < nb; i++) begin
            sdata_in = garbage ? bit'((i * 5) % 3 == 1) : tx_bit(i);
            sclk_in = 0;
            for (int k = 0; k < lo; k++) begin
                @(negedge clk);
                if (wiggle) begin cs_n = ~cs_n; wr_n = (k % 2) == 0; end
            end
            sclk_in = 1;
            for (int k = 0; k < hi; k++) begin
                @(negedge clk);
                if (wiggle) begin cs_n = ~cs_n; wr_n = (k % 2) == 1; end
            end
        end
        sclk_in = 0;
    endtask

    task automatic check_stream(input string tag);
        chk(rx_q.size() == tx_q.size(), tag, rx_q.size(), tx_q.size());
        for (int i = 0; i < tx_q.size() && i < rx_q.size(); i++)
            chk(rx_q[i] == tx_q[i], tag, rx_q[i], tx_q[i]);
        chk(done_cnt == 1, "R8 single load_done", done_cnt, 1);
    endtask

    task automatic slave_run(input int lo, input int hi, input bit wiggle, input string tag);
        do_reset();
        master_mode = 0;
        byte_total = CW'(tx_q.size());
        slave_bits(16, 3, 3, 1'b0, 1'b1);  // R2: traffic before init_ready
        repeat (6) @(negedge clk);
        chk(rx_q.size() == 0 && done_cnt == 0, "R2 no capture before init", rx_q.size(), 0);
        init_ready = 1;
        repeat (2) @(negedge clk);
        slave_bits(tx_q.size() * 8, lo, hi, wiggle, 1'b0);
        wait_done(50);
        check_stream(tag);
        slave_bits(16, 3, 3, 1'b0, 1'b1);  // R8: traffic after done
        repeat (6) @(negedge clk);
        chk(rx_q.size() == tx_q.size(), "R8 no bytes after done", rx_q.size(), tx_q.size());
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // master mode
        tx_q = '{8'h80, 8'h01, 8'hA5, 8'hFF};
        do_reset();
        master_mode = 1;
        byte_total = CW'(4);
        sdata_in = tx_bit(0);
        repeat (8) @(negedge clk);
        chk(cclk_out == 0 && rx_q.size() == 0, "R2 master idle", cclk_out, 0);
        init_ready = 1;
        fork
            begin
                for (int i = 1; i < 32; i++) begin
                    @(posedge cclk_out);
                    @(negedge clk);
                    sdata_in = tx_bit(i);
                end
            end
            wait_done(400);
        join
        repeat (10) @(negedge clk);
        check_stream("R4 master stream");
        chk(cclk_out == 0, "R8 cclk stopped", cclk_out, 0);

        // slave mode, still control pins
        tx_q = '{8'h3C, 8'h96, 8'h0F};
        slave_run(3, 3, 1'b0, "R5 slave stream");
        // slave mode, minimum phases, control pins toggling
        slave_run(2, 2, 1'b1, "R10 slave with cs/wr toggling");

        // zero length
        tx_q = {};
        do_reset();
        master_mode = 1;
        byte_total = '0;
        init_ready = 1;
        @(negedge clk);
        chk(load_done == 1, "R9 immediate done", load_done, 1);
        repeat (12) @(negedge clk);
        chk(done_cnt == 1 && rx_q.size() == 0, "R9 no bytes", rx_q.size(), 0);
        chk(cclk_out == 0, "R9 no clock", cclk_out, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule